// File: doc/BRIEF.md
# Interleaved Host-to-Device Address Decoder

This block sits in a memory expander endpoint. It maps one window of host physical address space onto the device's local address space. A 32-bit register port programs the window: a 64-bit base, a 64-bit size and a control word. The control word holds the interleave granularity, the interleave way count and a commit handshake. The decoder starts translating only after a commit.

At run time a request presents a host address and says whether it is a read or a write. The block subtracts the base and checks that the result lies inside the window. It then forms the device address by cutting the way-selector bits out of the offset. The bits below the selector pass through unchanged. The bits above the selector move down to close the gap.

Each response is registered once and comes out one cycle after its request. It carries a hit flag, the device address and an error flag. The error flag is raised only for a read that misses the window or that lands beyond the backing capacity. A write that misses is dropped quietly.

Top module: `hpa_window_decoder`

## Requirements
- R1: After reset every register reads back as zero, the decoder is inactive and no response is valid.
- R2: Register index 0/1 holds the low/high 32 bits of the base, index 2/3 the low/high 32 bits of the size, and index 4 the control word. Each 64-bit value is formed as {high, low}. Every register reads back what was written, through the same index on `regRdData`.
- R3: The control word layout is: granularity IG in bits [3:0], way count IW in bits [7:4], COMMIT in bit 8, ERR in bit 9, COMMITTED in bit 10. A control write is stored as written. When its COMMIT bit is 1, the stored word instead has COMMIT=0, ERR=0 and COMMITTED=1, and the decoder becomes active on the next cycle.
- R4: While COMMITTED is 0, every request misses.
- R5: A host address below the base misses. A missing response reports a device address of zero.
- R6: With offset = address − base, an offset equal to or above the size misses, and an offset of size−1 hits.
- R7: The lowest 8+IG bits of the offset appear unchanged at the bottom of the device address.
- R8: Offset bits from position 8+IG+IW upward appear shifted down by IW. The IW bits between those two groups are discarded.
- R9: A read that misses gets an error response. A write that misses gets no error and no hit.
- R10: A read hit whose device address is strictly greater than the CAPACITY parameter gets an error. A device address equal to CAPACITY does not. Writes never get an error.
- R11: When 8+IG+IW exceeds the SEL_LIMIT parameter, the request misses.
- R12: `rspValid` is high exactly in the cycle after a cycle with `reqValid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index for write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Contents of the register at `regAddr` (combinational) |
| reqValid | input | 1 | Translation request present |
| reqWrite | input | 1 | Request is a write (1) or a read (0) |
| reqAddr | input | 64 | Host physical address |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspHit | output | 1 | Address fell inside the active window |
| rspErr | output | 1 | Error response for a read |
| rspDpa | output | 64 | Translated device address, zero on a miss |

## Verification
The assertions assume the requester drives `reqValid` and `reqWrite` at known levels in every cycle after reset. They also assume that register writes and requests may occur in the same cycle, and that the response then reflects the configuration held before that write. The bench drives all inputs at the falling edge, holds each strobe for exactly one cycle, and never changes the configuration while a request is in flight. So every expected response follows from a single, settled configuration. The bench computes expected device addresses with its own bit-by-bit model, which copies the offset bits that lie outside the selector field.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  localparam int ADDR_W    = 64;
  localparam int REG_W     = 32;
  localparam int FIELD_W   = 4;
  localparam int GRAN_BASE = 8;
  localparam int WORDS     = ADDR_W / REG_W;
  localparam int CTRL_IDX  = 2 * WORDS;
  localparam int REG_IDX_W = $clog2(CTRL_IDX + 1);
  localparam int SHIFT_W   = $clog2(ADDR_W) + 1;

  localparam int CTRL_IG_LSB        = 0;
  localparam int CTRL_IW_LSB        = 4;
  localparam int CTRL_COMMIT_BIT    = 8;
  localparam int CTRL_ERR_BIT       = 9;
  localparam int CTRL_COMMITTED_BIT = 10;

  // Strobes and settings handed from the control side to the datapath
  typedef struct packed {
    logic [ADDR_W-1:0]  base;
    logic [ADDR_W-1:0]  size;
    logic [FIELD_W-1:0] gran;
    logic [FIELD_W-1:0] ways;
    logic               active;
  } decCfg_t;
endpackage

// File: rtl/dec_ctrl_regs.sv
module dec_ctrl_regs
  import addr_dec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_IDX_W-1:0] regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  output decCfg_t              cfg
);
  logic [WORDS-1:0][REG_W-1:0] baseQ;
  logic [WORDS-1:0][REG_W-1:0] sizeQ;
  logic [REG_W-1:0]            ctrlQ;
  logic [REG_W-1:0]            ctrlNext;

  // Word registers for base and size, one per REG_W slice
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[w] <= '0;
        sizeQ[w] <= '0;
      end else if (regWrEn) begin
        if (regAddr == REG_IDX_W'(w))         baseQ[w] <= regWrData;
        if (regAddr == REG_IDX_W'(WORDS + w)) sizeQ[w] <= regWrData;
      end
    end
  end

  // Commit handshake: the written word is kept, then the handshake bits resolve
  always_comb begin
    ctrlNext = regWrData;
    if (regWrData[CTRL_COMMIT_BIT]) begin
      ctrlNext[CTRL_COMMIT_BIT]    = 1'b0;
      ctrlNext[CTRL_ERR_BIT]       = 1'b0;
      ctrlNext[CTRL_COMMITTED_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= '0;
    else if (regWrEn && regAddr == REG_IDX_W'(CTRL_IDX)) ctrlQ <= ctrlNext;
  end

  always_comb begin
    regRdData = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (regAddr == REG_IDX_W'(w))         regRdData = baseQ[w];
      if (regAddr == REG_IDX_W'(WORDS + w)) regRdData = sizeQ[w];
    end
    if (regAddr == REG_IDX_W'(CTRL_IDX)) regRdData = ctrlQ;
  end

  assign cfg.base   = baseQ;
  assign cfg.size   = sizeQ;
  assign cfg.gran   = ctrlQ[CTRL_IG_LSB +: FIELD_W];
  assign cfg.ways   = ctrlQ[CTRL_IW_LSB +: FIELD_W];
  assign cfg.active = ctrlQ[CTRL_COMMITTED_BIT];
endmodule

// File: rtl/dec_xlate_path.sv
module dec_xlate_path
  import addr_dec_pkg::*;
#(
  parameter int                SEL_LIMIT = 52,
  parameter logic [ADDR_W-1:0] CAPACITY  = 64'h0000_0001_0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  decCfg_t           cfg,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspErr,
  output logic [ADDR_W-1:0] rspDpa
);
  logic [ADDR_W:0]    diff;
  logic [ADDR_W-1:0]  offset;
  logic               belowBase;
  logic               inSize;
  logic [SHIFT_W-1:0] lowBits;
  logic [SHIFT_W-1:0] selTop;
  logic               shiftOk;
  logic [ADDR_W-1:0]  lowMask;
  logic [ADDR_W-1:0]  dpaCalc;
  logic               hit;
  logic               beyondCap;
  logic               err;

  // Window check: the extra top bit of the subtraction flags an address below base
  assign diff      = {1'b0, reqAddr} - {1'b0, cfg.base};
  assign belowBase = diff[ADDR_W];
  assign offset    = diff[ADDR_W-1:0];
  assign inSize    = offset < cfg.size;

  // Selector placement and removal
  assign lowBits = SHIFT_W'(GRAN_BASE) + SHIFT_W'(cfg.gran);
  assign selTop  = lowBits + SHIFT_W'(cfg.ways);
  assign shiftOk = int'(selTop) <= SEL_LIMIT;
  assign lowMask = (ADDR_W'(1) << lowBits) - ADDR_W'(1);
  assign dpaCalc = (offset & lowMask) | ((offset >> selTop) << lowBits);

  assign hit       = cfg.active && !belowBase && inSize && shiftOk;
  assign beyondCap = dpaCalc > CAPACITY;
  assign err       = !reqWrite && (!hit || beyondCap);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspErr   <= 1'b0;
      rspDpa   <= '0;
    end else begin
      rspValid <= reqValid;
      rspHit   <= reqValid && hit;
      rspErr   <= reqValid && err;
      rspDpa   <= (reqValid && hit) ? dpaCalc : '0;
    end
  end
endmodule

// File: rtl/hpa_window_decoder.sv
module hpa_window_decoder
  import addr_dec_pkg::*;
#(
  parameter int                SEL_LIMIT = 52,
  parameter logic [ADDR_W-1:0] CAPACITY  = 64'h0000_0001_0000_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_IDX_W-1:0] regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  output logic                 rspValid,
  output logic                 rspHit,
  output logic                 rspErr,
  output logic [ADDR_W-1:0]    rspDpa
);
  decCfg_t cfgBus;
  logic    cfgActive;

  dec_ctrl_regs u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .cfg       (cfgBus)
  );

  dec_xlate_path #(
    .SEL_LIMIT (SEL_LIMIT),
    .CAPACITY  (CAPACITY)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfgBus),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .rspValid (rspValid),
    .rspHit   (rspHit),
    .rspErr   (rspErr),
    .rspDpa   (rspDpa)
  );

  assign cfgActive = cfgBus.active;
endmodule

// File: rtl/hpa_window_decoder_chk.sv
module hpa_window_decoder_chk
  import addr_dec_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic [REG_IDX_W-1:0] regAddr,
  input logic [REG_W-1:0]     regWrData,
  input logic                 reqValid,
  input logic                 reqWrite,
  input logic                 rspValid,
  input logic                 rspHit,
  input logic                 rspErr,
  input logic [ADDR_W-1:0]    rspDpa,
  input logic                 cfgActive
);
  assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_rsp_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  assert_commit_activates_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == REG_IDX_W'(CTRL_IDX) && regWrData[CTRL_COMMIT_BIT]) |=> cfgActive);

  assert_idle_misses_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !cfgActive) |=> !rspHit);

  assert_miss_zero_dpa_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> rspDpa == '0);

  assert_write_no_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> !rspErr);

  assert_read_miss_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> (rspHit || rspErr));
endmodule

bind hpa_window_decoder hpa_window_decoder_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .reqValid  (reqValid),
  .reqWrite  (reqWrite),
  .rspValid  (rspValid),
  .rspHit    (rspHit),
  .rspErr    (rspErr),
  .rspDpa    (rspDpa),
  .cfgActive (cfgActive)
);

// File: tb/tb_hpa_window_decoder.sv
module tb_hpa_window_decoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] CAP = 64'h0000_0000_0010_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [63:0] reqAddr = '0;
  logic        rspValid, rspHit, rspErr;
  logic [63:0] rspDpa;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpa_window_decoder #(.SEL_LIMIT(30), .CAPACITY(CAP)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .rspValid(rspValid),
    .rspHit(rspHit), .rspErr(rspErr), .rspDpa(rspDpa)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Independent model: keep offset bits outside the selector field, packed downward
  function automatic logic [63:0] modelDpa(logic [63:0] off, int ig, int iw);
    logic [63:0] r = '0;
    int j = 0;
    for (int i = 0; i < 64; i++) begin
      if (i < 8 + ig || i >= 8 + ig + iw) begin
        r[j] = off[i];
        j++;
      end
    end
    return r;
  endfunction

  task automatic writeReg(logic [2:0] idx, logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = idx; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(logic [2:0] idx, output logic [31:0] data);
    @(negedge clk);
    regAddr = idx;
    #1 data = regRdData;
  endtask

  task automatic access(logic wr, logic [63:0] addr);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic setWindow(logic [63:0] base, logic [63:0] size);
    writeReg(3'd0, base[31:0]);
    writeReg(3'd1, base[63:32]);
    writeReg(3'd2, size[31:0]);
    writeReg(3'd3, size[63:32]);
  endtask

  task automatic testReset();
    logic [31:0] d;
    for (int i = 0; i < 5; i++) begin
      readReg(3'(i), d);
      chk("R1", "reg after reset", 64'(d), 64'h0);
    end
    chk("R1", "rspValid after reset", 64'(rspValid), 64'h0);
  endtask

  task automatic testRegisters();
    logic [31:0] d;
    setWindow(64'h0000_0001_0000_0000, 64'h0000_0000_0020_0000);
    readReg(3'd1, d); chk("R2", "base hi", 64'(d), 64'h1);
    readReg(3'd0, d); chk("R2", "base lo", 64'(d), 64'h0);
    readReg(3'd2, d); chk("R2", "size lo", 64'(d), 64'h0020_0000);
    readReg(3'd3, d); chk("R2", "size hi", 64'(d), 64'h0);
  endtask

  task automatic testUncommitted();
    logic [31:0] d;
    writeReg(3'd4, 32'h0000_0010);
    readReg(3'd4, d); chk("R3", "ctrl stored without commit", 64'(d), 64'h10);
    access(1'b0, 64'h0000_0001_0000_0100);
    chk("R4", "hit before commit", 64'(rspHit), 64'h0);
    chk("R4", "err before commit", 64'(rspErr), 64'h1);
  endtask

  task automatic testCommit();
    logic [31:0] d;
    writeReg(3'd4, 32'h0000_0310);
    readReg(3'd4, d); chk("R3", "ctrl after commit", 64'(d), 64'h410);
  endtask

  task automatic testBounds();
    access(1'b0, 64'h0000_0000_FFFF_FFFF);
    chk("R5", "below base hit", 64'(rspHit), 64'h0);
    chk("R5", "below base dpa", rspDpa, 64'h0);
    access(1'b0, 64'h0000_0001_001F_FFFF);
    chk("R6", "last byte hit", 64'(rspHit), 64'h1);
    chk("R6", "last byte dpa", rspDpa, modelDpa(64'h1F_FFFF, 0, 1));
    access(1'b0, 64'h0000_0001_0020_0000);
    chk("R6", "offset == size hit", 64'(rspHit), 64'h0);
  endtask

  task automatic testTranslate();
    access(1'b0, 64'h0000_0001_0001_2345);
    chk("R7", "dpa ig0 iw1", rspDpa, modelDpa(64'h1_2345, 0, 1));
    chk("R7", "low byte kept", 64'(rspDpa[7:0]), 64'h45);
    writeReg(3'd4, 32'h0000_0132);
    access(1'b0, 64'h0000_0001_000A_BCDE);
    chk("R8", "dpa ig2 iw3", rspDpa, modelDpa(64'hA_BCDE, 2, 3));
    access(1'b1, 64'h0000_0001_001F_0F0F);
    chk("R8", "write dpa ig2 iw3", rspDpa, modelDpa(64'h1F_0F0F, 2, 3));
  endtask

  task automatic testErrors();
    access(1'b1, 64'h0000_0000_0000_1000);
    chk("R9", "write miss hit", 64'(rspHit), 64'h0);
    chk("R9", "write miss err", 64'(rspErr), 64'h0);
    access(1'b0, 64'h0000_0000_0000_1000);
    chk("R9", "read miss err", 64'(rspErr), 64'h1);
    writeReg(3'd4, 32'h0000_0100);
    access(1'b0, 64'h0000_0001_0010_0000);
    chk("R10", "dpa == cap hit", 64'(rspHit), 64'h1);
    chk("R10", "dpa == cap err", 64'(rspErr), 64'h0);
    access(1'b0, 64'h0000_0001_0010_0001);
    chk("R10", "dpa > cap read err", 64'(rspErr), 64'h1);
    access(1'b1, 64'h0000_0001_0010_0001);
    chk("R10", "dpa > cap write err", 64'(rspErr), 64'h0);
    chk("R10", "dpa > cap write hit", 64'(rspHit), 64'h1);
  endtask

  task automatic testLimit();
    writeReg(3'd4, 32'h0000_01FF);
    access(1'b1, 64'h0000_0001_0000_0080);
    chk("R11", "8+IG+IW over limit hit", 64'(rspHit), 64'h0);
    writeReg(3'd4, 32'h0000_017F);
    access(1'b1, 64'h0000_0001_0000_0080);
    chk("R11", "8+IG+IW at limit hit", 64'(rspHit), 64'h1);
    chk("R11", "8+IG+IW at limit dpa", rspDpa, modelDpa(64'h80, 15, 7));
  endtask

  task automatic testDecommit();
    writeReg(3'd4, 32'h0000_0000);
    access(1'b1, 64'h0000_0001_0000_0080);
    chk("R4", "hit after decommit", 64'(rspHit), 64'h0);
  endtask

  task automatic testTiming();
    access(1'b0, 64'h0);
    chk("R12", "valid in response cycle", 64'(rspValid), 64'h1);
    @(negedge clk);
    chk("R12", "valid drops after", 64'(rspValid), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegisters();
    testUncommitted();
    testCommit();
    testBounds();
    testTranslate();
    testErrors();
    testLimit();
    testDecommit();
    testTiming();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule